// File: doc/BRIEF.md
# Synchronous DRAM Burst Read Sequencer

This block sits between a host read port and the command pins of a single-rank synchronous DRAM. A host presents a bank, row and column with a valid strobe. The sequencer opens the row with an ACTIVE command and waits a fixed row-to-column delay. It then issues a READ and keeps the command bus at NOP while the device streams the burst back after the programmed CAS latency. Once the burst has been received, it closes the row with a PRECHARGE to that bank.

Each word that arrives on the data pins is registered and passed on to the host as a valid/data beat, and the final beat carries a last flag. The row-to-column delay, the CAS latency (2 or 3) and the burst length (1, 2, 4 or 8) are elaboration parameters, so every edge of the sequence lands on a fixed cycle after the request is accepted. The block accepts one request at a time. The byte masks are held low for the whole operation. Clock enable is held low only while reset is asserted.

Top module: `sdr_read_sequencer`

## Requirements
- R1: The command pins {sdCsN, sdRasN, sdCasN, sdWeN} carry 4'b0011 for ACTIVE, 4'b0101 for READ, 4'b0111 for NOP and 4'b0010 for PRECHARGE, and they carry NOP in every cycle that holds none of the other three.
- R2: When reqValid and reqReady are both high at a rising edge, the next cycle carries ACTIVE, with reqBank on sdBa and reqRow on sdAddr.
- R3: READ appears exactly TRCD cycles after ACTIVE. It carries the latched bank on sdBa and the latched column on sdAddr[COL_W-1:0], and all higher address bits are zero, so sdAddr[10] (the auto-precharge bit) is low.
- R4: PRECHARGE appears TRCD+CAS_LAT+BURST_LEN cycles after ACTIVE, which is the cycle after the last burst word is on sdDq. It carries the latched bank on sdBa and zero on sdAddr, so sdAddr[10] is low and only one bank is closed.
- R5: The words on sdDq in the cycles READ+CAS_LAT through READ+CAS_LAT+BURST_LEN-1 come out on rdData in order, each one cycle later with rdValid high. rdLast is high only on the final beat, and rdValid is low in every other cycle.
- R6: reqReady is high only while no transaction is in progress, and it rises again in the PRECHARGE cycle. A reqValid that is presented while reqReady is low has no effect on the commands, the addresses or the returned data.
- R7: sdCke is low while rstN is low and high from the first rising edge after reset is released. sdDqm is always zero.
- R8: While rstN is low, the command pins carry NOP, rdValid and rdLast are low, and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the block and the device |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host read request valid |
| reqReady | output | 1 | High when a request can be accepted |
| reqBank | input | BANK_W (2) | Bank of the request |
| reqRow | input | ADDR_W (13) | Row of the request |
| reqCol | input | COL_W (10) | Starting column of the request |
| sdCke | output | 1 | Device clock enable |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | BANK_W (2) | Bank select to the device |
| sdAddr | output | ADDR_W (13) | Multiplexed row/column address to the device |
| sdDqm | output | DATA_W/8 (2) | Byte masks, held low |
| sdDq | input | DATA_W (16) | Read data from the device |
| rdValid | output | 1 | Returned beat valid |
| rdData | output | DATA_W (16) | Returned beat |
| rdLast | output | 1 | Marks the final beat of a burst |

## Verification
The bench sweeps all four banks against rows at zero, all ones and an alternating pattern, and against columns at zero, all ones and an alternating pattern. A behavioural device drives a word built from the bank, column and beat index that it decodes from the pins, so a wrong bank, column or beat order shows up as different data. Idle cycles carry a word the host can never expect, so a beat sampled one cycle early or late is caught as well. About half the requests keep reqValid high with inverted fields throughout the transaction, which separates a design that ignores busy-time requests from one that restarts or takes on the new address. Every cycle of every transaction is compared against the command, address, ready and data expected for that cycle offset.

// File: rtl/sdr_read_pkg.sv
package sdr_read_pkg;

  // Command codes as {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_ACTIVE    = 4'b0011,
    CMD_READ      = 4'b0101,
    CMD_NOP       = 4'b0111,
    CMD_PRECHARGE = 4'b0010
  } sdCmd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic issueAct;
    logic issueRead;
    logic issuePre;
    logic capture;
    logic captureLast;
  } seqStrobe_t;

endpackage

// File: rtl/sdr_read_ctrl.sv
module sdr_read_ctrl
  import sdr_read_pkg::*;
#(
  parameter int TRCD      = 2,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output seqStrobe_t strobe
);

  localparam int LAST_CNT  = TRCD + CAS_LAT + BURST_LEN;
  localparam int CAP_FIRST = TRCD + CAS_LAT + 1;
  localparam int CNT_W     = $clog2(LAST_CNT + 1);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(LAST_CNT);
  localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(CAP_FIRST);
  localparam logic [CNT_W-1:0] RCD_C   = CNT_W'(TRCD);
  localparam int BEAT_W    = $clog2(BURST_LEN + 1);

  typedef enum logic {ST_IDLE, ST_BUSY} state_e;

  state_e           state;
  logic [CNT_W-1:0] cycleCnt;   // cycles since the accept edge

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cycleCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state    <= ST_BUSY;
            cycleCnt <= CNT_W'(1);
          end
        end
        default: begin
          if (cycleCnt == LAST_C) begin
            state    <= ST_IDLE;
            cycleCnt <= '0;
          end else begin
            cycleCnt <= cycleCnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    reqReady = (state == ST_IDLE);
    strobe   = '0;
    if (state == ST_IDLE) begin
      strobe.latchReq = reqValid;
      strobe.issueAct = reqValid;
    end else begin
      strobe.issueRead   = (cycleCnt == RCD_C);
      strobe.capture     = (cycleCnt >= FIRST_C);
      strobe.captureLast = (cycleCnt == LAST_C);
      strobe.issuePre    = (cycleCnt == LAST_C);
    end
  end

  // Checker state: beats counted since the READ strobe
  logic [BEAT_W-1:0] beatsSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 beatsSeen <= '0;
    else if (strobe.issueRead) beatsSeen <= '0;
    else if (strobe.capture)   beatsSeen <= beatsSeen + BEAT_W'(1);
  end

  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqReady) |-> $past(reqValid));  // R6

  AST_BURST_BEATS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureLast |-> (beatsSeen == BEAT_W'(BURST_LEN - 1)));  // R5

endmodule

// File: rtl/sdr_read_datapath.sv
module sdr_read_datapath
  import sdr_read_pkg::*;
#(
  parameter int TRCD   = 2,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [ADDR_W-1:0]   reqRow,
  input  logic [COL_W-1:0]    reqCol,
  input  logic [DATA_W-1:0]   sdDq,
  output logic                sdCke,
  output logic [3:0]          sdCmd,
  output logic [BANK_W-1:0]   sdBa,
  output logic [ADDR_W-1:0]   sdAddr,
  output logic [DATA_W/8-1:0] sdDqm,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdLast
);

  localparam int GAP_W = $clog2(TRCD + 2) + 1;

  sdCmd_e            cmdQ;
  logic [BANK_W-1:0] bankQ;
  logic [COL_W-1:0]  colQ;
  logic [ADDR_W-1:0] readAddr;
  logic              ckeQ;

  // Column placement on the address bus; bits above it (including A10) are zero
  generate
    if (COL_W < ADDR_W) begin : g_colPad
      assign readAddr = {{(ADDR_W - COL_W){1'b0}}, colQ};
    end else begin : g_colFull
      assign readAddr = colQ[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ    <= CMD_NOP;
      sdBa    <= '0;
      sdAddr  <= '0;
      bankQ   <= '0;
      colQ    <= '0;
      ckeQ    <= 1'b0;
      rdValid <= 1'b0;
      rdLast  <= 1'b0;
      rdData  <= '0;
    end else begin
      ckeQ <= 1'b1;
      if (strobe.latchReq) begin
        bankQ <= reqBank;
        colQ  <= reqCol;
      end
      if (strobe.issueAct) begin
        cmdQ   <= CMD_ACTIVE;
        sdBa   <= reqBank;
        sdAddr <= reqRow;
      end else if (strobe.issueRead) begin
        cmdQ   <= CMD_READ;
        sdBa   <= bankQ;
        sdAddr <= readAddr;
      end else if (strobe.issuePre) begin
        cmdQ   <= CMD_PRECHARGE;
        sdBa   <= bankQ;
        sdAddr <= '0;
      end else begin
        cmdQ <= CMD_NOP;
      end
      rdValid <= strobe.capture;
      rdLast  <= strobe.captureLast;
      if (strobe.capture) rdData <= sdDq;
    end
  end

  assign sdCmd = cmdQ;
  assign sdCke = ckeQ;
  assign sdDqm = '0;

  // Checker state: cycles since the last ACTIVE on the pins
  logic [GAP_W-1:0] sinceAct;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     sinceAct <= '0;
    else if (cmdQ == CMD_ACTIVE)   sinceAct <= GAP_W'(1);
    else if (sinceAct != '1)       sinceAct <= sinceAct + GAP_W'(1);
  end

  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_READ) |-> (sinceAct == GAP_W'(TRCD)));  // R3

  AST_PRE_ON_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_PRECHARGE) |-> (rdValid && rdLast));  // R4

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> rdValid);  // R5

  AST_CKE_UP: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> sdCke);  // R7

endmodule

// File: rtl/sdr_read_sequencer.sv
module sdr_read_sequencer
  import sdr_read_pkg::*;
#(
  parameter int TRCD      = 2,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4,
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 13,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [ADDR_W-1:0]   reqRow,
  input  logic [COL_W-1:0]    reqCol,
  output logic                sdCke,
  output logic                sdCsN,
  output logic                sdRasN,
  output logic                sdCasN,
  output logic                sdWeN,
  output logic [BANK_W-1:0]   sdBa,
  output logic [ADDR_W-1:0]   sdAddr,
  output logic [DATA_W/8-1:0] sdDqm,
  input  logic [DATA_W-1:0]   sdDq,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdLast
);

  seqStrobe_t strobe;
  logic [3:0] sdCmd;

  sdr_read_ctrl #(
    .TRCD(TRCD), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqReady(reqReady), .strobe(strobe)
  );

  sdr_read_datapath #(
    .TRCD(TRCD), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
    .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .sdDq(sdDq), .sdCke(sdCke), .sdCmd(sdCmd),
    .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm),
    .rdValid(rdValid), .rdData(rdData), .rdLast(rdLast)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = sdCmd;

endmodule

// File: tb/tb_sdr_read_sequencer.sv
module tb_sdr_read_sequencer;

  localparam int TRCD = 2;
  localparam int CL   = 2;
  localparam int BL   = 4;
  localparam int PCYC = 1 + TRCD + CL + BL;     // PRECHARGE cycle after accept
  localparam int VCYC = TRCD + CL + 2;          // first rdValid cycle

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqBank = '0;
  logic [12:0] reqRow = '0;
  logic [9:0]  reqCol = '0;
  logic        sdCke, sdCsN, sdRasN, sdCasN, sdWeN;
  logic [1:0]  sdBa;
  logic [12:0] sdAddr;
  logic [1:0]  sdDqm;
  logic [15:0] sdDq = 16'h7E7E;
  logic        rdValid, rdLast;
  logic [15:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  sdr_read_sequencer #(.TRCD(TRCD), .CAS_LAT(CL), .BURST_LEN(BL)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm), .sdDq(sdDq),
    .rdValid(rdValid), .rdData(rdData), .rdLast(rdLast)
  );

  // Behavioural device: decodes READ on the pins, returns tagged words CL later
  bit         mPending = 0;
  int         mWait = 0;
  int         mBeat = 0;
  logic [1:0] mBank = '0;
  logic [9:0] mCol = '0;
  always @(negedge clk) begin
    if (mPending && mWait == 0) begin
      sdDq = {1'b1, mBank, mCol, 3'(mBeat)};
      mBeat++;
      if (mBeat == BL) mPending = 0;
    end else begin
      if (mPending) mWait--;
      sdDq = 16'h7E7E;
    end
    if ({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0101) begin
      mPending = 1; mWait = CL - 1; mBeat = 0;
      mBank = sdBa; mCol = sdAddr[9:0];
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input logic [1:0] b, input logic [9:0] c, input int i);
    return {1'b1, b, c, 3'(i)};
  endfunction

  task automatic runRead(input logic [1:0] bank, input logic [12:0] row,
                         input logic [9:0] col, input bit holdBusy);
    logic [3:0] cmd;
    @(negedge clk);
    chk("R6", "idle reqReady", 32'(reqReady), 32'd1);
    chk("R5", "idle rdValid", 32'(rdValid), 32'd0);
    reqValid = 1'b1; reqBank = bank; reqRow = row; reqCol = col;
    for (int n = 1; n <= PCYC; n++) begin
      @(negedge clk);
      if (n == 1) begin
        reqValid = holdBusy;
        reqBank = ~bank; reqRow = ~row; reqCol = ~col;
      end
      cmd = {sdCsN, sdRasN, sdCasN, sdWeN};
      if (n == 1) begin
        chk("R2", "ACTIVE cmd", 32'(cmd), 32'h3);
        chk("R2", "ACTIVE bank", 32'(sdBa), 32'(bank));
        chk("R2", "ACTIVE row", 32'(sdAddr), 32'(row));
      end else if (n == 1 + TRCD) begin
        chk("R3", "READ cmd", 32'(cmd), 32'h5);
        chk("R3", "READ bank", 32'(sdBa), 32'(bank));
        chk("R3", "READ addr", 32'(sdAddr), 32'(col));
      end else if (n == PCYC) begin
        chk("R4", "PRECHARGE cmd", 32'(cmd), 32'h2);
        chk("R4", "PRECHARGE bank", 32'(sdBa), 32'(bank));
        chk("R4", "PRECHARGE addr", 32'(sdAddr), 32'd0);
      end else begin
        chk("R1", "NOP cmd", 32'(cmd), 32'h7);
      end
      chk("R5", "rdValid", 32'(rdValid), 32'(n >= VCYC));
      chk("R5", "rdLast", 32'(rdLast), 32'(n == PCYC));
      if (n >= VCYC)
        chk("R5", "rdData", 32'(rdData), 32'(expWord(bank, col, n - VCYC)));
      chk("R6", "busy reqReady", 32'(reqReady), 32'(n == PCYC));
      chk("R7", "dqm", 32'(sdDqm), 32'd0);
      if (n == PCYC) reqValid = 1'b0;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    finishRun();
  end

  initial begin
    logic [12:0] rows [3];
    logic [9:0]  cols [3];
    rows[0] = 13'h0000; rows[1] = 13'h1FFF; rows[2] = 13'h0AAA;
    cols[0] = 10'h000;  cols[1] = 10'h3FF;  cols[2] = 10'h155;
    repeat (2) @(negedge clk);
    chk("R7", "cke in reset", 32'(sdCke), 32'd0);
    chk("R8", "cmd in reset", 32'({sdCsN, sdRasN, sdCasN, sdWeN}), 32'h7);
    chk("R8", "rdValid in reset", 32'(rdValid), 32'd0);
    chk("R8", "rdLast in reset", 32'(rdLast), 32'd0);
    chk("R8", "reqReady in reset", 32'(reqReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R7", "cke after reset", 32'(sdCke), 32'd1);
    chk("R7", "dqm after reset", 32'(sdDqm), 32'd0);
    chk("R1", "idle NOP", 32'({sdCsN, sdRasN, sdCasN, sdWeN}), 32'h7);
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++)
          runRead(2'(b), rows[r], cols[c], ((b + r + c) % 2) == 1);
    repeat (3) begin
      @(negedge clk);
      chk("R1", "trailing NOP", 32'({sdCsN, sdRasN, sdCasN, sdWeN}), 32'h7);
      chk("R5", "trailing rdValid", 32'(rdValid), 32'd0);
    end
    finishRun();
  end

endmodule